// File: doc/BRIEF.md
# Burst QPSK Bit Demultiplexer

This block sits at the front of a burst QPSK transmitter. It divides the master clock to make a bit clock, which it sends to the data source. Bursts of serial bits are clocked in against that bit clock and split into I/Q pairs. Each finished pair goes to the pulse-shaping filters as a one-cycle symbol strobe. The strobe carries the two raw bits and the signs that the pair gives on each axis.

The source holds the enable high for the whole burst. The bits are timed by the exported clock. The first bit that is sampled with the enable high is always an I bit, and after that the bits alternate. A burst should have an even number of bits. If a burst ends on an unpaired bit, that bit is sent as a symbol with Q forced to 0, and an error pulse is raised.

The transmit-active indication stays high after the enable drops. It stays high long enough for the shaping filters to empty, counted as a fixed number of symbol periods after the last strobe. An active-low reset clears all state at once. Operation resumes two master-clock cycles after the reset is released.

Top module: `qpsk_bit_demux`

## Requirements
- R1: `bit_clk` has a period of DIV master-clock cycles. It is low for DIV/2 cycles and high for the rest of the period (defaults: 100 cycles, high 50).
- R2: After `rst_n` rises, the block stays idle for 2 cycles and the divider then starts from zero. `bit_clk` is first seen high after DIV/2+2 rising edges of `clk`.
- R3: Driving `rst_n` low clears `tx_active`, `sym_stb` and `bit_clk` with no clock edge needed. A half-received pair is dropped and is never emitted later.
- R4: Inputs are sampled on the clock edge where `bit_clk` falls. The first bit sampled with `tx_en` high after an idle period goes to I. The bits that follow alternate Q, I, Q. Each completed pair gives one `sym_stb` with `sym_i`/`sym_q`, and those outputs hold their value between strobes.
- R5: The axis signs follow the phase map (I,Q)=00→45°, 01→135°, 10→−45°, 11→−135°. This means `ax_i_neg` equals the Q bit and `ax_q_neg` equals the I bit (1 = negative amplitude).
- R6: If `tx_en` is sampled low while an I bit is pending, the block emits a symbol with that I bit and Q=0. `odd_err` is high in that strobe cycle and only then.
- R7: `tx_active` goes high at the first enabled bit sample. It falls exactly 2·FLUSH_SYMS·DIV cycles after the last `sym_stb` (default 1600). It changes only on `bit_clk` falling edges.
- R8: If `tx_en` rises again while the stretch is still running, `tx_active` stays high. The new burst's first bit goes to I.
- R9: While `tx_en` is sampled low and no bit is pending, `tx_data` has no effect: no strobe is issued.
- R10: `sym_stb` lasts one cycle, falls together with `bit_clk`, and occurs only while `tx_active` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Burst enable from the data source |
| tx_data | input | 1 | Serial burst data |
| bit_clk | output | 1 | Exported bit clock (master/DIV) |
| sym_stb | output | 1 | One-cycle symbol strobe |
| sym_i | output | 1 | I bit of the current symbol |
| sym_q | output | 1 | Q bit of the current symbol |
| ax_i_neg | output | 1 | I-axis amplitude is negative |
| ax_q_neg | output | 1 | Q-axis amplitude is negative |
| odd_err | output | 1 | Unpaired trailing bit was padded |
| tx_active | output | 1 | Stretched transmit-active indication |

## Verification
The bench checks the phase map with all four bit pairs in one burst. A design that swaps the axes would show 135° and −45° interchanged. It sends a burst with an odd bit count: a block that drops the last bit, or fails to clear Q, misses a symbol or sends a stale Q. It measures the stretch to the exact cycle and re-enables before the stretch expires. An off-by-one counter, or a pairing flag left set across bursts, is exposed there. A reset is applied in the middle of a pair to catch a block that clears only on a clock edge or emits a late symbol. Finally, `tx_data` toggles while idle; a block that samples it would produce strobes.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
   typedef struct packed {
      logic i_bit;
      logic q_bit;
   } qbd_pair_t;

   typedef struct packed {
      logic i_neg;
      logic q_neg;
   } qbd_axis_t;

   // Q bit flips the in-phase axis, I bit flips the quadrature axis
   function automatic qbd_axis_t qbd_map(input qbd_pair_t p);
      qbd_axis_t r;
      r.i_neg = p.q_bit;
      r.q_neg = p.i_bit;
      return r;
   endfunction
endpackage

// File: rtl/qbd_rst_sync.sv
module qbd_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_i_n
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("qbd_rst_sync: STAGES must be at least 1");
      end else if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_i_n <= 1'b0;
            else        rst_i_n <= 1'b1;
         end
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], 1'b1};
         end
         assign rst_i_n = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/qbd_bit_timer.sv
module qbd_bit_timer #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst_i_n,
   output logic bit_clk,
   output logic tick
);
   localparam int CW = $clog2(DIV);
   localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);
   localparam logic [CW-1:0] HALF_C = CW'(DIV / 2);

   logic [CW-1:0] div_cnt;

   assign tick    = (div_cnt == LAST_C);
   assign bit_clk = (div_cnt >= HALF_C);

   always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n)  div_cnt <= '0;
      else if (tick) div_cnt <= '0;
      else           div_cnt <= div_cnt + 1'b1;
   end
endmodule

// File: rtl/qbd_pairer.sv
module qbd_pairer
   import qbd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_i_n,
   input  logic      tick,
   input  logic      en,
   input  logic      din,
   output logic      emit,
   output logic      stb,
   output qbd_pair_t pair,
   output qbd_axis_t axis,
   output logic      odd_err
);
   logic      have_i;
   logic      hold_i;
   qbd_pair_t nxt;

   // a pending I bit is released on the next sample either way
   assign emit      = tick && have_i;
   assign nxt.i_bit = hold_i;
   assign nxt.q_bit = en ? din : 1'b0;

   always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) begin
         have_i  <= 1'b0;
         hold_i  <= 1'b0;
         stb     <= 1'b0;
         pair    <= '0;
         axis    <= '0;
         odd_err <= 1'b0;
      end else begin
         stb     <= emit;
         odd_err <= emit && !en;
         if (emit) begin
            pair <= nxt;
            axis <= qbd_map(nxt);
         end
         if (tick) begin
            if (en && !have_i) begin
               hold_i <= din;
               have_i <= 1'b1;
            end else begin
               have_i <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/qbd_flush.sv
module qbd_flush #(
   parameter int FLUSH_TICKS = 16
) (
   input  logic clk,
   input  logic rst_i_n,
   input  logic tick,
   input  logic en,
   input  logic emit,
   output logic active
);
   localparam int FW = $clog2(FLUSH_TICKS + 1);
   localparam logic [FW-1:0] LOAD_C = FW'(FLUSH_TICKS);
   localparam logic [FW-1:0] ONE_C  = FW'(1);

   logic [FW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (tick) begin
         if (en || emit) begin
            cnt    <= LOAD_C;
            active <= 1'b1;
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == ONE_C) active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/qpsk_bit_demux.sv
module qpsk_bit_demux
   import qbd_pkg::*;
#(
   parameter int DIV        = 100,
   parameter int FLUSH_SYMS = 8,
   parameter int RST_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic tx_data,
   output logic bit_clk,
   output logic sym_stb,
   output logic sym_i,
   output logic sym_q,
   output logic ax_i_neg,
   output logic ax_q_neg,
   output logic odd_err,
   output logic tx_active
);
   localparam int BITS_PER_SYM = 2;
   localparam int FLUSH_TICKS  = FLUSH_SYMS * BITS_PER_SYM;

   generate
      if (DIV < 4) begin : g_bad_div
         $error("qpsk_bit_demux: DIV must be at least 4");
      end
      if (FLUSH_SYMS < 1) begin : g_bad_flush
         $error("qpsk_bit_demux: FLUSH_SYMS must be at least 1");
      end
   endgenerate

   logic      rst_i_n;
   logic      tick;
   logic      emit;
   qbd_pair_t pair;
   qbd_axis_t axis;

   qbd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
      .clk(clk), .rst_n(rst_n), .rst_i_n(rst_i_n)
   );

   qbd_bit_timer #(.DIV(DIV)) u_tmr (
      .clk(clk), .rst_i_n(rst_i_n), .bit_clk(bit_clk), .tick(tick)
   );

   qbd_pairer u_pair (
      .clk(clk), .rst_i_n(rst_i_n), .tick(tick), .en(tx_en), .din(tx_data),
      .emit(emit), .stb(sym_stb), .pair(pair), .axis(axis), .odd_err(odd_err)
   );

   qbd_flush #(.FLUSH_TICKS(FLUSH_TICKS)) u_flush (
      .clk(clk), .rst_i_n(rst_i_n), .tick(tick), .en(tx_en), .emit(emit),
      .active(tx_active)
   );

   assign sym_i    = pair.i_bit;
   assign sym_q    = pair.q_bit;
   assign ax_i_neg = axis.i_neg;
   assign ax_q_neg = axis.q_neg;
endmodule

// File: rtl/qbd_checker.sv
module qbd_checker (
   input logic clk,
   input logic rst_n,
   input logic bit_clk,
   input logic sym_stb,
   input logic sym_i,
   input logic sym_q,
   input logic ax_i_neg,
   input logic ax_q_neg,
   input logic odd_err,
   input logic tx_active
);
   a_r10_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
      sym_stb |=> !sym_stb);

   a_r10_stb_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      sym_stb |-> $fell(bit_clk));

   a_r10_stb_active: assert property (@(posedge clk) disable iff (!rst_n)
      sym_stb |-> tx_active);

   a_r6_odd_q_zero: assert property (@(posedge clk) disable iff (!rst_n)
      odd_err |-> (sym_stb && !sym_q));

   a_r5_axis_map: assert property (@(posedge clk) disable iff (!rst_n)
      sym_stb |-> ((ax_i_neg == sym_q) && (ax_q_neg == sym_i)));

   a_r7_active_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active != $past(tx_active)) |-> $fell(bit_clk));

   a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_stb |-> $stable({sym_i, sym_q}));
endmodule

bind qpsk_bit_demux qbd_checker u_chk (
   .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .sym_stb(sym_stb),
   .sym_i(sym_i), .sym_q(sym_q), .ax_i_neg(ax_i_neg), .ax_q_neg(ax_q_neg),
   .odd_err(odd_err), .tx_active(tx_active)
);

// File: tb/sim_qpsk_bit_demux.sv
module sim_qpsk_bit_demux;
   localparam int DIV        = 100;
   localparam int FLUSH_SYMS = 8;
   localparam int HALF       = DIV / 2;
   localparam int STRETCH    = 2 * FLUSH_SYMS * DIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0;
   logic tx_data = 1'b0;
   logic bit_clk, sym_stb, sym_i, sym_q, ax_i_neg, ax_q_neg, odd_err, tx_active;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int n_stb = 0;
   int last_stb = 0;
   bit flush_chk = 1'b0;
   bit prev_act = 1'b0;
   bit done = 1'b0;
   logic [2:0] exp_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   qpsk_bit_demux #(.DIV(DIV), .FLUSH_SYMS(FLUSH_SYMS)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data),
      .bit_clk(bit_clk), .sym_stb(sym_stb), .sym_i(sym_i), .sym_q(sym_q),
      .ax_i_neg(ax_i_neg), .ax_q_neg(ax_q_neg), .odd_err(odd_err),
      .tx_active(tx_active)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: scoreboard pop and stretch timing
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_act = 1'b0;
      end else begin
         if (sym_stb) begin
            n_stb++;
            last_stb = cyc;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9", "unexpected strobe", 1, 0);
            end else begin
               logic [2:0] e;
               e = exp_q.pop_front();
               chk({sym_i, sym_q, odd_err} == e, "R4/R6", "symbol {i,q,odd}",
                   int'({sym_i, sym_q, odd_err}), int'(e));
               chk({ax_i_neg, ax_q_neg} == {e[1], e[2]}, "R5", "axis signs",
                   int'({ax_i_neg, ax_q_neg}), int'({e[1], e[2]}));
            end
         end
         if (flush_chk && prev_act && !tx_active)
            chk(cyc - last_stb == STRETCH, "R7", "stretch cycles",
                cyc - last_stb, STRETCH);
         prev_act = tx_active;
      end
   end

   task automatic bit_slot(input logic en, input logic d);
      @(posedge bit_clk);
      #1;
      tx_en   = en;
      tx_data = d;
   endtask

   task automatic burst(input logic [31:0] b, input int n);
      for (int k = 0; k < n; k++) begin
         bit_slot(1'b1, b[k]);
         if (k % 2 == 1) exp_q.push_back({b[k-1], b[k], 1'b0});
      end
      if (n % 2 == 1) exp_q.push_back({b[n-1], 1'b0, 1'b1});
      bit_slot(1'b0, 1'b0);
   endtask

   task automatic drain();
      repeat (2 * FLUSH_SYMS + 3) @(posedge bit_clk);
      #1;
   endtask

   task automatic release_and_measure();
      int n;
      @(negedge clk);
      rst_n = 1'b1;
      n = 0;
      do begin
         @(posedge clk);
         n++;
         #1;
      end while (!bit_clk && n < 4 * DIV);
      chk(n == HALF + 2, "R2", "edges to first bit_clk high", n, HALF + 2);
   endtask

   initial begin
      int t_rise, t_fall, t_next, stb0;
      repeat (5) @(posedge clk);
      #1;
      chk({bit_clk, sym_stb, odd_err, tx_active} == 4'b0, "R3", "outputs in reset",
          int'({bit_clk, sym_stb, odd_err, tx_active}), 0);
      release_and_measure();
      flush_chk = 1'b1;

      // R1 bit clock shape
      @(posedge bit_clk); t_rise = cyc;
      @(negedge bit_clk); t_fall = cyc;
      @(posedge bit_clk); t_next = cyc;
      chk(t_next - t_rise == DIV, "R1", "bit_clk period", t_next - t_rise, DIV);
      chk(t_fall - t_rise == DIV - HALF, "R1", "bit_clk high time", t_fall - t_rise, DIV - HALF);

      // R9 idle data is ignored
      stb0 = n_stb;
      for (int k = 0; k < 6; k++) bit_slot(1'b0, k[0]);
      @(posedge bit_clk); #1;
      chk(n_stb == stb0, "R9", "strobes while idle", n_stb - stb0, 0);
      chk(tx_active == 1'b0, "R9", "tx_active while idle", int'(tx_active), 0);

      // R4/R5 all four pairs: 00,01,10,11 (I first)
      burst(32'b11_01_10_00, 8);
      chk(tx_active == 1'b1, "R7", "active right after enable drop", int'(tx_active), 1);
      drain();
      chk(tx_active == 1'b0, "R7", "inactive after drain", int'(tx_active), 0);

      // R6 odd burst
      burst(32'b1_11_00, 5);
      drain();
      chk(exp_q.size() == 0, "R6", "pending symbols after odd burst", exp_q.size(), 0);

      // R8 re-enable during the stretch
      burst(32'b10_01, 4);
      bit_slot(1'b0, 1'b1);
      bit_slot(1'b0, 1'b0);
      #1;
      chk(tx_active == 1'b1, "R8", "active held into re-enable", int'(tx_active), 1);
      burst(32'b0110_1001_1, 9);
      drain();

      // R3 reset in the middle of a pair
      flush_chk = 1'b0;
      bit_slot(1'b1, 1'b1);
      bit_slot(1'b1, 1'b0);
      exp_q.push_back({1'b1, 1'b0, 1'b0});
      bit_slot(1'b1, 1'b1);
      @(posedge clk);
      #3;
      rst_n = 1'b0;
      #1;
      chk({tx_active, sym_stb, bit_clk} == 3'b0, "R3", "immediate clear",
          int'({tx_active, sym_stb, bit_clk}), 0);
      tx_en = 1'b0;
      repeat (5) @(posedge clk);
      release_and_measure();
      flush_chk = 1'b1;
      stb0 = n_stb;
      repeat (4) @(posedge bit_clk);
      #1;
      chk(n_stb == stb0, "R3", "no late symbol after reset", n_stb - stb0, 0);
      chk(exp_q.size() == 0, "R4", "scoreboard empty", exp_q.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule